// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block sits on the controller side of a single-data-rate synchronous DRAM. After reset it holds the memory's command bus in a quiet state for the settling time. It then runs the start-up order: an all-bank precharge, a train of auto-refresh commands and a load of the mode register. Each step is followed by a counted wait. When the last wait ends it raises `init_done`, and from then on it paces the periodic refresh the memory needs.

Refresh is requested, not forced. At the end of each refresh interval the block raises `refresh_req`. It keeps the request high until an external arbiter answers with `refresh_grant`. It then takes the bus for one refresh: precharge all banks, wait, auto refresh, wait. After that it drops the request. If an interval runs out while a request is still unanswered, a saturating missed-refresh counter steps up.

All timings are given in nanoseconds and turned into clock counts by rounding up against the clock period parameter. The mode word is built from parameters.

Top module: `sdram_boot_refresh_seq`

## Requirements
- R1: During reset and for exactly PWR_CYC = ceil(POWERUP_NS*1000/CLK_PERIOD_PS) cycles after reset is released (the release cycle counted), the command pins {cs_n,ras_n,cas_n,we_n} read 4'b0111 (no-op). Throughout, cke is 1, every dqm bit is 1, and init_done, refresh_req and missed_refreshes are 0.
- R2: The first command after the settling time is precharge-all, 4'b0010 with addr[10]=1. It is followed by exactly TRP_CYC no-op cycles, where TRP_CYC is TRP_NS rounded up to whole clocks.
- R3: Next come INIT_REFRESHES auto-refresh commands (4'b0001). Each one is followed by exactly TARFC_CYC no-op cycles.
- R4: Next comes one mode-register load (4'b0000) with ba=0. Its addr carries the burst-length code in bits 2:0, the interleave flag in bit 3, the CAS latency code in bits 6:4 (3'b010 = 2, 3'b011 = 3) and the single-write flag in bit 9. All other bits are 0.
- R5: After the mode-register load come two no-op cycles with init_done=0. init_done is 1 in the following cycle and stays 1 until reset.
- R6: refresh_req first reads 1 exactly REFI_CYC cycles after the first cycle in which init_done reads 1. Intervals repeat every REFI_CYC cycles. refresh_req is never 1 while init_done is 0.
- R7: While the block is ready and not refreshing, the command pins stay at no-op. A pending request stays high for as long as no grant is seen. refresh_grant has no effect while refresh_req is 0.
- R8: If refresh_grant is 1 in a cycle where refresh_req is 1, the next cycle carries precharge-all with addr[10]=1. Then come TRP_CYC no-ops, one auto refresh and TARFC_CYC no-ops. refresh_req reads 0 in the cycle after the last of those no-ops.
- R9: missed_refreshes steps by one when an interval ends while a request is still pending. It holds at 15 and is unchanged by a completed refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| refresh_grant | input | 1 | Arbiter's permission to take the bus for a refresh |
| cke | output | 1 | Clock enable to the memory, held high |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address bus; A10 selects all banks on precharge |
| dqm | output | DQM_W | Data mask lanes, held high |
| init_done | output | 1 | Start-up sequence finished |
| refresh_req | output | 1 | A refresh is due and waiting for a grant |
| missed_refreshes | output | 4 | Saturating count of intervals that ran out with a request pending |

## Verification
The bench counts the exact no-op gaps between start-up commands. A design that is off by one on a wait, or that issues too few or too many auto refreshes, would move a command by a cycle or change the command count. It checks that the mode word lands on the right address bits and that init_done waits out both cycles after the load. On the refresh side it probes the cycle just before and just after the first interval ends. It also holds off the grant and checks that the request stays up and the bus stays quiet, and that a grant with no request starts nothing. Finally it starves the block long enough for the missed counter to pass its limit: a counter that wraps instead of saturating would read a small value.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  // Command pins packed as {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_NOP  = 4'b0111,
    CMD_PALL = 4'b0010,
    CMD_AREF = 4'b0001,
    CMD_MRS  = 4'b0000
  } sd_cmd_e;

  typedef enum logic [3:0] {
    ST_PWRUP, ST_IPALL, ST_ITRP, ST_IAREF, ST_ITARFC, ST_MRS, ST_TMRD,
    ST_READY, ST_RPALL, ST_RTRP, ST_RAREF, ST_RTARFC
  } seq_state_e;

  // Nanoseconds to whole clocks, rounded up, never below one
  function automatic int ns_to_clk(input int ns, input int period_ps);
    int c;
    c = (ns * 1000 + period_ps - 1) / period_ps;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int W       = 8,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= W'(RST_VAL);
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  AST_TIMER_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R2
endmodule

// File: rtl/refresh_pacer.sv
module refresh_pacer #(
  parameter int INTERVAL = 1000,
  parameter int MISS_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              done,
  output logic              req,
  output logic [MISS_W-1:0] missed
);
  localparam int CW = $clog2(INTERVAL + 1);
  localparam logic [MISS_W-1:0] MISS_MAX = '1;

  logic [CW-1:0] cnt_q;
  logic          tick, pending;

  assign tick    = run && (cnt_q == '0);
  assign pending = req && !done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= CW'(INTERVAL - 1);
      req    <= 1'b0;
      missed <= '0;
    end else begin
      if (!run || cnt_q == '0) cnt_q <= CW'(INTERVAL - 1);
      else                     cnt_q <= cnt_q - 1'b1;
      req <= tick | pending;
      if (tick && pending && missed != MISS_MAX) missed <= missed + 1'b1;
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !done) |=> req); // R7
  AST_MISS_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (missed == MISS_MAX) |=> (missed == MISS_MAX)); // R9
  AST_MISS_STEPS_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (missed == $past(missed) || missed == $past(missed) + 1'b1)); // R9
endmodule

// File: rtl/sdram_boot_refresh_seq.sv
module sdram_boot_refresh_seq
  import sdram_seq_pkg::*;
#(
  parameter int CLK_PERIOD_PS   = 7000,
  parameter int POWERUP_NS      = 200000,
  parameter int TRP_NS          = 20,
  parameter int TARFC_NS        = 75,
  parameter int REFI_NS         = 7800,
  parameter int INIT_REFRESHES  = 8,
  parameter int ADDR_W          = 13,
  parameter int BA_W            = 2,
  parameter int DQM_W           = 2,
  parameter logic [2:0] MR_BURST_CODE   = 3'b010,
  parameter logic       MR_INTERLEAVE   = 1'b0,
  parameter logic [2:0] MR_CAS_CODE     = 3'b011,
  parameter logic       MR_SINGLE_WRITE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              refresh_grant,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic [DQM_W-1:0]  dqm,
  output logic              init_done,
  output logic              refresh_req,
  output logic [3:0]        missed_refreshes
);
  localparam int PWR_CYC   = ns_to_clk(POWERUP_NS, CLK_PERIOD_PS);
  localparam int TRP_CYC   = ns_to_clk(TRP_NS, CLK_PERIOD_PS);
  localparam int TARFC_CYC = ns_to_clk(TARFC_NS, CLK_PERIOD_PS);
  localparam int REFI_CYC  = ns_to_clk(REFI_NS, CLK_PERIOD_PS);
  localparam int MRD_CYC   = 2;
  localparam int MAX_WAIT  = (PWR_CYC > TARFC_CYC) ?
                             ((PWR_CYC > TRP_CYC) ? PWR_CYC : TRP_CYC) :
                             ((TARFC_CYC > TRP_CYC) ? TARFC_CYC : TRP_CYC);
  localparam int TW        = $clog2(MAX_WAIT + 1);
  localparam int RC_W      = $clog2(INIT_REFRESHES + 1);
  localparam int AP_BIT    = 10;
  localparam logic [12:0] MODE_CORE = {3'b000, MR_SINGLE_WRITE, 2'b00,
                                       MR_CAS_CODE, MR_INTERLEAVE, MR_BURST_CODE};
  localparam logic [ADDR_W-1:0] MODE_WORD = ADDR_W'(MODE_CORE);

  seq_state_e    state_q, state_d;
  sd_cmd_e       cmd;
  logic          t_load, t_zero, seq_done;
  logic [TW-1:0] t_val;
  logic [RC_W-1:0] ref_cnt_q;

  seq_timer #(.W(TW), .RST_VAL(PWR_CYC - 1)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .zero(t_zero));

  refresh_pacer #(.INTERVAL(REFI_CYC), .MISS_W(4)) u_pacer (
    .clk(clk), .rst_n(rst_n), .run(init_done), .done(seq_done),
    .req(refresh_req), .missed(missed_refreshes));

  always_comb begin
    state_d  = state_q;
    t_load   = 1'b0;
    t_val    = '0;
    seq_done = 1'b0;
    unique case (state_q)
      ST_PWRUP:  if (t_zero) state_d = ST_IPALL;
      ST_IPALL:  begin t_load = 1'b1; t_val = TW'(TRP_CYC - 1); state_d = ST_ITRP; end
      ST_ITRP:   if (t_zero) state_d = ST_IAREF;
      ST_IAREF:  begin t_load = 1'b1; t_val = TW'(TARFC_CYC - 1); state_d = ST_ITARFC; end
      ST_ITARFC: if (t_zero)
                   state_d = (ref_cnt_q == RC_W'(INIT_REFRESHES)) ? ST_MRS : ST_IAREF;
      ST_MRS:    begin t_load = 1'b1; t_val = TW'(MRD_CYC - 1); state_d = ST_TMRD; end
      ST_TMRD:   if (t_zero) state_d = ST_READY;
      ST_READY:  if (refresh_req && refresh_grant) state_d = ST_RPALL;
      ST_RPALL:  begin t_load = 1'b1; t_val = TW'(TRP_CYC - 1); state_d = ST_RTRP; end
      ST_RTRP:   if (t_zero) state_d = ST_RAREF;
      ST_RAREF:  begin t_load = 1'b1; t_val = TW'(TARFC_CYC - 1); state_d = ST_RTARFC; end
      ST_RTARFC: if (t_zero) begin seq_done = 1'b1; state_d = ST_READY; end
      default:   state_d = ST_PWRUP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_PWRUP;
      ref_cnt_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IAREF) ref_cnt_q <= ref_cnt_q + 1'b1;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_IPALL, ST_RPALL: cmd = CMD_PALL;
      ST_IAREF, ST_RAREF: cmd = CMD_AREF;
      ST_MRS:             cmd = CMD_MRS;
      default:            cmd = CMD_NOP;
    endcase
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd;
  assign addr = (cmd == CMD_MRS)  ? MODE_WORD :
                (cmd == CMD_PALL) ? (ADDR_W'(1) << AP_BIT) : '0;
  assign ba        = '0;
  assign cke       = 1'b1;
  assign dqm       = '1;
  assign init_done = (state_q == ST_READY) || (state_q == ST_RPALL) ||
                     (state_q == ST_RTRP)  || (state_q == ST_RAREF) ||
                     (state_q == ST_RTARFC);

  AST_PALL_SELECTS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    ({cs_n, ras_n, cas_n, we_n} == CMD_PALL) |-> addr[AP_BIT]); // R2
  AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done); // R5
  AST_NO_REQ_BEFORE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !refresh_req); // R6
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && !refresh_req) |-> ({cs_n, ras_n, cas_n, we_n} == CMD_NOP)); // R7
endmodule

// File: tb/tb_sdram_boot_refresh_seq.sv
module tb_sdram_boot_refresh_seq;
  localparam int PERIOD_PS = 4000;
  localparam int PWR  = 100;   // 400 ns
  localparam int TRP  = 5;     // 18 ns
  localparam int TARF = 15;    // 60 ns
  localparam int REFI = 300;   // 1200 ns
  localparam int NREF = 8;
  localparam logic [2:0] BL = 3'b011, CL = 3'b010;
  localparam logic BT = 1'b1, SW = 1'b1;
  localparam logic [3:0] NOP = 4'b0111, PALL = 4'b0010, AREF = 4'b0001, MRS = 4'b0000;

  logic clk = 1'b0, rst_n = 1'b0, grant = 1'b0;
  logic cke, cs_n, ras_n, cas_n, we_n, init_done, req;
  logic [1:0] ba, dqm;
  logic [12:0] addr;
  logic [3:0] missed;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  sdram_boot_refresh_seq #(
    .CLK_PERIOD_PS(PERIOD_PS), .POWERUP_NS(400), .TRP_NS(18), .TARFC_NS(60),
    .REFI_NS(1200), .INIT_REFRESHES(NREF),
    .MR_BURST_CODE(BL), .MR_INTERLEAVE(BT), .MR_CAS_CODE(CL), .MR_SINGLE_WRITE(SW)
  ) dut (
    .clk(clk), .rst_n(rst_n), .refresh_grant(grant), .cke(cke), .cs_n(cs_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .dqm(dqm),
    .init_done(init_done), .refresh_req(req), .missed_refreshes(missed));

  wire [3:0] cmd = {cs_n, ras_n, cas_n, we_n};

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_cmd(output int gap, output logic [3:0] c);
    gap = 0;
    c = NOP;
    while (gap < 20000) begin
      @(negedge clk);
      c = cmd;
      if (c != NOP) break;
      gap++;
    end
  endtask

  task automatic test_reset_and_init();
    int gap;
    logic [3:0] c;
    logic [12:0] mode_exp;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 nop in reset", cmd, NOP);
    chk("R1 cke", cke, 1);
    chk("R1 dqm", dqm, 3);
    chk("R1 flags", {init_done, req, missed}, 0);
    rst_n = 1'b1;
    chk("R1 nop at release", cmd, NOP);
    wait_cmd(gap, c);
    chk("R1 settle gap", gap, PWR - 1);
    chk("R2 precharge-all", c, PALL);
    chk("R2 A10", addr[10], 1);
    wait_cmd(gap, c);
    chk("R2 trp gap", gap, TRP);
    for (int i = 0; i < NREF; i++) begin
      chk("R3 auto refresh", c, AREF);
      wait_cmd(gap, c);
      chk("R3 tarfc gap", gap, TARF);
    end
    mode_exp = {3'b000, SW, 2'b00, CL, BT, BL};
    chk("R4 mode load", c, MRS);
    chk("R4 bank", ba, 0);
    chk("R4 mode word", addr, mode_exp);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk("R5 mrd wait", {cmd, init_done}, {NOP, 1'b0});
    end
    @(negedge clk);
    chk("R5 ready", init_done, 1);
  endtask

  task automatic test_first_request();
    repeat (REFI - 1) @(negedge clk);
    chk("R6 before interval", req, 0);
    @(negedge clk);
    chk("R6 at interval", req, 1);
  endtask

  task automatic test_hold_without_grant();
    int bad = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (!req || cmd != NOP) bad++;
    end
    chk("R7 request held, bus quiet", bad, 0);
  endtask

  task automatic run_granted_refresh(input string tag);
    int gap, bad;
    logic [3:0] c;
    grant = 1'b1;
    @(negedge clk);
    grant = 1'b0;
    chk({tag, " precharge after grant"}, cmd, PALL);
    chk({tag, " A10"}, addr[10], 1);
    wait_cmd(gap, c);
    chk({tag, " trp gap"}, gap, TRP);
    chk({tag, " auto refresh"}, c, AREF);
    bad = 0;
    for (int i = 0; i < TARF; i++) begin
      @(negedge clk);
      if (!req || cmd != NOP) bad++;
    end
    chk({tag, " tarfc wait"}, bad, 0);
    @(negedge clk);
    chk({tag, " request dropped"}, req, 0);
  endtask

  task automatic test_grant_ignored();
    int bad = 0;
    grant = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (req || cmd != NOP) bad++;
    end
    grant = 1'b0;
    chk("R7 grant without request", bad, 0);
  endtask

  task automatic test_missed();
    int n = 0;
    while (!req && n < 2 * REFI) begin
      @(negedge clk);
      n++;
    end
    chk("R6 next interval", req, 1);
    chk("R9 none missed yet", missed, 0);
    repeat (REFI - 1) @(negedge clk);
    chk("R9 before expiry", missed, 0);
    @(negedge clk);
    chk("R9 one missed", missed, 1);
    repeat (20 * REFI) @(negedge clk);
    chk("R9 saturated", missed, 15);
    run_granted_refresh("R8");
    chk("R9 kept after refresh", missed, 15);
  endtask

  initial begin
    test_reset_and_init();
    test_first_request();
    test_hold_without_grant();
    run_granted_refresh("R8");
    chk("R9 zero after serviced", missed, 0);
    test_grant_ignored();
    test_missed();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule